// File: doc/BRIEF.md
# Page access permission evaluator

This combinational block decides which access rights a translated page grants and whether the requested access must fault. A page table walker supplies the combined user, read/write and no-execute flags it accumulated across the levels of the walk. It also supplies the protection key of the leaf entry, which is held in entry bits 62:59. The core supplies the privilege of the access, the access type, the mode enables and the two protection-key rights registers.

The block produces read, write and execute permission bits for the page. It also produces a fault flag with its kind: an ordinary protection fault or a protection-key fault. The permission bits are always driven, whether or not a fault is reported, so that a translation cache can store them.

The evaluation runs in three stages:

1. A base stage applies the supervisor-access guards for user pages, which block supervisor reads and supervisor fetches, and applies the write-protect override.
2. A key stage picks a rights register by page ownership and reads the key's two rights bits.
3. An arbitration stage merges the two results and ranks the possible faults.

Top module: `perm_eval`

## Requirements
- R1: A user-mode access (`acc_user`=1) to a page with `pg_user`=0 reports `fault`=1 with `fault_is_key`=0, whatever the key rights say.
- R2: Read is granted unless `smap_on`=1 and `pg_user`=1. When read is withheld, write is withheld too.
- R3: When read is not withheld, write is granted if `pg_rw`=1, or if the access is supervisor-mode and `en_wp`=0.
- R4: Execute is granted when `pg_nx`=0 and either `acc_user`=1 or not (`en_smep`=1 and `pg_user`=1).
- R5: The key rights word is taken as follows:
  - For a page with `pg_user`=1, it is `usr_rights` when `en_pke`=1.
  - For a page with `pg_user`=0, it is `sup_rights` when `en_pks`=1.
  - In every other case the key rights word is zero and the keys have no effect.
- R6: For key k (`leaf_key`), bit 2k of the rights word is access-disable and bit 2k+1 is write-disable. Access-disable removes read and write. Write-disable removes write only when `acc_user`=1 or `en_wp`=1.
- R7: When the key rights deny the requested access, the block reports `fault`=1 with `fault_is_key`=1. This takes precedence over an ordinary protection fault. The output permissions are the base permissions ANDed with the key rights.
- R8: Protection keys never remove execute permission and never raise a fault for an instruction fetch.
- R9: `acc_type` is encoded 0 for load (needs read), 1 for store (needs write), 2 for fetch (needs execute) and 3 for a load. If the final permission for the requested access is clear, the block reports `fault`=1 with `fault_is_key`=0. Otherwise `fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pg_user | input | 1 | Combined user flag of the walk |
| pg_rw | input | 1 | Combined writable flag of the walk |
| pg_nx | input | 1 | Combined no-execute flag (1 forbids fetch) |
| acc_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| smap_on | input | 1 | Supervisor guard against user-page data access is active for this access |
| en_wp | input | 1 | Write-protect enable for supervisor writes |
| en_smep | input | 1 | Supervisor guard against user-page fetch |
| en_pke | input | 1 | Enable protection keys for user pages |
| en_pks | input | 1 | Enable protection keys for supervisor pages |
| usr_rights | input | 32 | Key rights register for user pages |
| sup_rights | input | 32 | Key rights register for supervisor pages |
| leaf_key | input | 4 | Protection key of the leaf entry (entry bits 62:59) |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| fault | output | 1 | The requested access faults |
| fault_is_key | output | 1 | The fault is a protection-key fault |

## Verification
The hardest case is a key whose rights bits deny the access while the page itself would also deny it. In that case the key fault must win, except when a user access reaches a supervisor page, where the protection fault must win. Only one key's two bits in one rights register decide the outcome, so a random rights word rarely lines up with the key. The stimulus therefore computes the rights words: pseudo-random background bits, with the selected key's pair forced to each of its four values. It gives the two registers opposite pairs, so that picking the wrong register shows at the outputs. This is swept across every combination of page flags, privilege, access type and mode enables, for three keys including both end keys.

// File: rtl/perm_pkg.sv
package perm_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    function automatic logic needed_bit(perm_t p, acc_e t);
        logic b;
        unique case (t)
            ACC_STORE: b = p.wr;
            ACC_FETCH: b = p.ex;
            default:   b = p.rd;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/key_rights.sv
module key_rights #(
    parameter int KEY_W = 4
) (
    input  logic                        page_user,
    input  logic                        en_pke,
    input  logic                        en_pks,
    input  logic [2*(1<<KEY_W)-1:0]     usr_rights,
    input  logic [2*(1<<KEY_W)-1:0]     sup_rights,
    input  logic [KEY_W-1:0]            key,
    output logic                        key_ad,
    output logic                        key_wd
);
    localparam int NKEYS = 1 << KEY_W;
    localparam int RW    = 2 * NKEYS;

    logic [RW-1:0]    sel;
    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;

    always_comb begin
        if (page_user)
            sel = en_pke ? usr_rights : '0;
        else
            sel = en_pks ? sup_rights : '0;
    end

    for (genvar i = 0; i < NKEYS; i++) begin : g_key
        assign ad_vec[i] = sel[2*i];
        assign wd_vec[i] = sel[2*i+1];
    end

    assign key_ad = ad_vec[key];
    assign key_wd = wd_vec[key];

    always_comb begin
        if (!$isunknown({page_user, en_pke, en_pks, key_ad, key_wd}))
            AST_DISABLED_KEYS_QUIET: assert (!(( page_user && !en_pke) ||
                                                (!page_user && !en_pks)) ||
                                              !(key_ad || key_wd)); // R5
    end
endmodule

// File: rtl/base_perm.sv
module base_perm
    import perm_pkg::*;
(
    input  logic  pg_user,
    input  logic  pg_rw,
    input  logic  pg_nx,
    input  logic  acc_user,
    input  logic  smap_on,
    input  logic  en_wp,
    input  logic  en_smep,
    output perm_t base
);
    logic rd_ok;

    always_comb begin
        rd_ok   = !(smap_on && pg_user);
        base.rd = rd_ok;
        base.wr = rd_ok && (pg_rw || !(acc_user || en_wp));
        base.ex = !pg_nx && (acc_user || !(en_smep && pg_user));
    end

    always_comb begin
        if (!$isunknown({base, smap_on, pg_user}))
            AST_SMAP_BLOCKS_DATA: assert (!(smap_on && pg_user) ||
                                          !(base.rd || base.wr)); // R2
    end
endmodule

// File: rtl/fault_arb.sv
module fault_arb
    import perm_pkg::*;
(
    input  perm_t      base,
    input  logic       key_ad,
    input  logic       key_wd,
    input  logic       acc_user,
    input  logic       en_wp,
    input  logic       pg_user,
    input  logic [1:0] acc_type,
    output perm_t      granted,
    output logic       fault,
    output logic       fault_is_key
);
    acc_e  typ;
    perm_t key_perm;
    logic  user_viol;
    logic  key_deny;
    logic  prot_deny;

    assign typ = acc_e'(acc_type);

    always_comb begin
        key_perm.rd = !key_ad;
        key_perm.wr = !key_ad && !(key_wd && (acc_user || en_wp));
        key_perm.ex = 1'b1;
        granted     = base & key_perm;
        user_viol   = acc_user && !pg_user;
        key_deny    = !needed_bit(key_perm, typ);
        prot_deny   = !needed_bit(granted, typ);
        fault        = 1'b0;
        fault_is_key = 1'b0;
        if (user_viol) begin
            fault = 1'b1;
        end else if (key_deny) begin
            fault        = 1'b1;
            fault_is_key = 1'b1;
        end else if (prot_deny) begin
            fault = 1'b1;
        end
    end

    always_comb begin
        if (!$isunknown({fault, fault_is_key, acc_type, granted})) begin
            AST_KEY_NEEDS_FAULT: assert (!fault_is_key || fault); // R7
            AST_FETCH_NO_KEY_FAULT: assert (!(typ == ACC_FETCH) || !fault_is_key); // R8
            AST_GRANT_MEANS_NO_FAULT: assert (fault || needed_bit(granted, typ)); // R9
        end
    end
endmodule

// File: rtl/perm_eval.sv
module perm_eval
    import perm_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                pg_user,
    input  logic                pg_rw,
    input  logic                pg_nx,
    input  logic                acc_user,
    input  logic [1:0]          acc_type,
    input  logic                smap_on,
    input  logic                en_wp,
    input  logic                en_smep,
    input  logic                en_pke,
    input  logic                en_pks,
    input  logic [RIGHTS_W-1:0] usr_rights,
    input  logic [RIGHTS_W-1:0] sup_rights,
    input  logic [KEY_W-1:0]    leaf_key,
    output logic                perm_r,
    output logic                perm_w,
    output logic                perm_x,
    output logic                fault,
    output logic                fault_is_key
);
    perm_t base;
    perm_t granted;
    logic  key_ad;
    logic  key_wd;

    base_perm u_base (
        .pg_user  (pg_user),
        .pg_rw    (pg_rw),
        .pg_nx    (pg_nx),
        .acc_user (acc_user),
        .smap_on  (smap_on),
        .en_wp    (en_wp),
        .en_smep  (en_smep),
        .base     (base)
    );

    key_rights #(.KEY_W(KEY_W)) u_keys (
        .page_user  (pg_user),
        .en_pke     (en_pke),
        .en_pks     (en_pks),
        .usr_rights (usr_rights),
        .sup_rights (sup_rights),
        .key        (leaf_key),
        .key_ad     (key_ad),
        .key_wd     (key_wd)
    );

    fault_arb u_arb (
        .base         (base),
        .key_ad       (key_ad),
        .key_wd       (key_wd),
        .acc_user     (acc_user),
        .en_wp        (en_wp),
        .pg_user      (pg_user),
        .acc_type     (acc_type),
        .granted      (granted),
        .fault        (fault),
        .fault_is_key (fault_is_key)
    );

    assign perm_r = granted.rd;
    assign perm_w = granted.wr;
    assign perm_x = granted.ex;

    always_comb begin
        if (!$isunknown({perm_r, perm_w, perm_x, fault, fault_is_key,
                         acc_user, pg_user, pg_nx})) begin
            AST_WRITE_NEEDS_READ: assert (!perm_w || perm_r); // R2
            AST_USER_ON_SUP_PAGE: assert (!(acc_user && !pg_user) ||
                                          (fault && !fault_is_key)); // R1
            AST_NX_NO_EXEC: assert (!pg_nx || !perm_x); // R4
        end
    end
endmodule

// File: tb/tb_perm_eval.sv
module tb_perm_eval;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        pg_user, pg_rw, pg_nx, acc_user, smap_on;
    logic        en_wp, en_smep, en_pke, en_pks;
    logic [1:0]  acc_type;
    logic [31:0] usr_rights, sup_rights;
    logic [3:0]  leaf_key;
    logic        perm_r, perm_w, perm_x, fault, fault_is_key;

    int vectors = 0;
    int errs = 0;

    perm_eval dut (
        .pg_user(pg_user), .pg_rw(pg_rw), .pg_nx(pg_nx),
        .acc_user(acc_user), .acc_type(acc_type), .smap_on(smap_on),
        .en_wp(en_wp), .en_smep(en_smep), .en_pke(en_pke), .en_pks(en_pks),
        .usr_rights(usr_rights), .sup_rights(sup_rights), .leaf_key(leaf_key),
        .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
        .fault(fault), .fault_is_key(fault_is_key)
    );

    logic e_r, e_w, e_x, e_f, e_k;

    task automatic model();
        logic [31:0] rw;
        logic ad, wd, kr, kw, need_k, need_g;
        // R2 R3 R4: base rights
        e_r = !(smap_on && pg_user);
        e_w = e_r && (pg_rw || (!acc_user && !en_wp));
        e_x = !pg_nx && (acc_user || !(en_smep && pg_user));
        // R5: register selection
        if (pg_user) rw = en_pke ? usr_rights : 32'd0;
        else         rw = en_pks ? sup_rights : 32'd0;
        // R6: key bit pair
        ad = rw[2*leaf_key];
        wd = rw[2*leaf_key+1];
        kr = !ad;
        kw = !ad && !(wd && (acc_user || en_wp));
        // R8: execute untouched by keys
        e_r = e_r && kr;
        e_w = e_w && kw;
        case (acc_type)
            2'd1: begin need_k = kw;   need_g = e_w; end
            2'd2: begin need_k = 1'b1; need_g = e_x; end
            default: begin need_k = kr; need_g = e_r; end
        endcase
        // R1 first, then R7, then R9
        if (acc_user && !pg_user) begin e_f = 1; e_k = 0; end
        else if (!need_k)         begin e_f = 1; e_k = 1; end
        else if (!need_g)         begin e_f = 1; e_k = 0; end
        else                      begin e_f = 0; e_k = 0; end
    endtask

    task automatic cmp(string tag, logic act, logic exp);
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %b expected %b (pu=%b rw=%b nx=%b au=%b t=%0d smap=%b wp=%b smep=%b pke=%b pks=%b key=%0d)",
                     tag, act, exp, pg_user, pg_rw, pg_nx, acc_user, acc_type,
                     smap_on, en_wp, en_smep, en_pke, en_pks, leaf_key);
        end
    endtask

    task automatic check();
        @(negedge clk);
        model();
        vectors++;
        cmp("R2 perm_r", perm_r, e_r);
        cmp("R3 perm_w", perm_w, e_w);
        cmp("R4 perm_x", perm_x, e_x);
        cmp("R9 fault", fault, e_f);
        cmp("R7 fault_is_key", fault_is_key, e_k);
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        {pg_user, pg_rw, pg_nx, acc_user, smap_on, en_wp, en_smep, en_pke, en_pks} = '0;
        acc_type = 2'd0; usr_rights = '0; sup_rights = '0; leaf_key = '0;
        repeat (2) @(posedge clk);
        // idle: all-zero inputs, supervisor load of a supervisor read-only page
        check();
        for (int ki = 0; ki < 3; ki++) begin
            for (int pair = 0; pair < 4; pair++) begin
                for (int c = 0; c < 2048; c++) begin
                    logic [31:0] bg_u, bg_s;
                    logic [3:0]  k;
                    k = (ki == 0) ? 4'd0 : (ki == 1) ? 4'd5 : 4'd15;
                    bg_u = (c + 1) * 32'h9E3779B9 ^ (pair * 32'h85EBCA6B);
                    bg_s = (c + 7) * 32'hC2B2AE35 ^ (ki * 32'h27D4EB2F);
                    // R5 R6: opposite pairs in the two registers for key k
                    bg_u[2*k +: 2] = pair[1:0];
                    bg_s[2*k +: 2] = ~pair[1:0];
                    {pg_user, pg_rw, pg_nx, acc_user, acc_type,
                     smap_on, en_wp, en_smep, en_pke, en_pks} = c[10:0];
                    usr_rights = bg_u;
                    sup_rights = bg_s;
                    leaf_key   = k;
                    // R1 R8 covered by acc_user/pg_user and acc_type=2 combinations
                    check();
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule